// File: doc/BRIEF.md
# Converter Serial Command Port

This block is the slave side of a four-wire serial port that sits in front of a data converter core. The host frames each access with an active-low chip select. It first sends an 8-bit command word, most significant bit first. That word names one of eight register slots, says whether the access reads or writes, and carries three control flags: software reset, standby and filter sync. A data phase follows. It shifts 24 bits out of the conversion result, 8 bits out of the status slot, or a parameter-wide word into or out of any other slot. The converter core and its configuration registers are outside the block. The core hands over results on a data port with a valid strobe. Register writes leave on a strobe with an address and a data word, and register reads come back on a read-data port.

All port inputs are brought into the system clock domain through two-flop synchronizers, and serial clock edges are found in that domain. The clock idle level seen when chip select falls picks the polarity. Data always changes on the first edge of each bit and is sampled on the second. A resync rule returns the port to command wait after a run of ones. A continuous mode lets the host fetch each new result with a bare 24-clock burst.

Top module: `adc_cmd_port`

## Requirements
- R1: The serial clock level sampled when cs_n falls sets the polarity: low idle means launch on rising and capture on falling, and high idle means the reverse. Out of reset, before any cs_n fall, high idle is assumed.
- R2: After reset, rdy_n is 1, standby, fsync and reg_sel are 0, and dout is 0. While cs_n is high, dout_en and dout stay 0.
- R3: The command byte has bit7 = 0 (start bit), bits 6:4 = slot, bit3 = 1 for read, bit2 = software reset, bit1 = standby, bit0 = filter sync. Each command updates reg_sel, standby and fsync. A write to slot 1..6 takes REG_W data bits MSB first, then pulses reg_wr for one cycle with reg_wdata. A write to slot 0 has no data phase, and a write to slot 7 takes 24 bits and raises no reg_wr.
- R4: A read of slot 1..6 shifts reg_rdata out MSB first over REG_W bits. A read of slot 0 shifts out 8 status bits: {ready, 000, 1, 0, standby, fsync}.
- R5: data_valid sets the ready flag (rdy_n = 0). A read of slot 7 shifts data_word out MSB first over 24 bits, and finishing all 24 bits clears the ready flag.
- R6: Ones captured while waiting for a command are ignored. The first 0 is taken as a start bit.
- R7: 32 consecutive captured ones outside continuous mode abort any transfer and return the port to command wait. A half-done write raises no reg_wr, and standby, fsync and reg_sel keep their values.
- R8: The exact command 0x78 issued while scan_en is 1 enters continuous mode after its 24-bit read. Each later burst of 24 clocks with din held at 1 shifts out the current data_word again. Without scan_en the port returns to command wait.
- R9: In continuous mode, a 0 in the first bit of a burst ends the mode, and that bit is taken as the start bit of a new command.
- R10: A command with bit2 set pulses soft_rst. It returns reg_sel, standby, fsync and the ready flag to their reset values and leaves the port in command wait.
- R11: cs_n rising during a command or data phase discards the partial transfer. The next selection starts from command wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock from host |
| din | input | 1 | Serial data from host |
| dout | output | 1 | Serial data to host, 0 when not driving |
| dout_en | output | 1 | High while the port drives read data |
| data_word | input | 24 | Latest conversion result from the core |
| data_valid | input | 1 | One-cycle strobe: a new result is on data_word |
| scan_en | input | 1 | Channel scan active; permits continuous mode |
| reg_rdata | input | REG_W | Read value of the slot on reg_sel |
| reg_sel | output | 3 | Slot named by the last command |
| reg_wdata | output | REG_W | Data word of the last register write |
| reg_wr | output | 1 | One-cycle write strobe for reg_sel |
| standby | output | 1 | Standby flag from the last command |
| fsync | output | 1 | Filter sync flag from the last command |
| soft_rst | output | 1 | One-cycle software reset strobe |
| rdy_n | output | 1 | Active-low data ready |

## Verification
The hardest state to reach is the 32-ones resync in the middle of a transfer. It only matters where a data phase is longer than 32 bits, so the bench builds the port with 40-bit registers. It starts a write, sends four zero bits, then sends 32 ones, so the resync lands before the write would complete. A follow-up command then checks that the port is aligned again. Continuous mode is reached by pulsing data_valid around a 0x78 command with scan_en high. The exit from continuous mode is driven by a start bit in the first position of a burst.

// File: rtl/adc_cmd_port.sv
module adc_cmd_port #(
  parameter int REG_W       = 16,
  parameter int DATA_W      = 24,
  parameter int RESYNC_ONES = 32,
  parameter int DATA_SEL    = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              din,
  output logic              dout,
  output logic              dout_en,
  input  logic [DATA_W-1:0] data_word,
  input  logic              data_valid,
  input  logic              scan_en,
  input  logic [REG_W-1:0]  reg_rdata,
  output logic [2:0]        reg_sel,
  output logic [REG_W-1:0]  reg_wdata,
  output logic              reg_wr,
  output logic              standby,
  output logic              fsync,
  output logic              soft_rst,
  output logic              rdy_n
);
  localparam int TXW = (REG_W > DATA_W) ? REG_W : DATA_W;
  localparam int CW  = $clog2(TXW + 1);
  localparam int OW  = $clog2(RESYNC_ONES + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_CMD, ST_XFER, ST_CONT} st_t;

  st_t          st;
  logic         cs_m, cs_s, cs_p, sk_m, sk_s, sk_p, di_m, di_s;
  logic         cpol, rdy, rw_q, cont_arm, dout_q;
  logic [6:0]   cmd_sr;
  logic [CW-1:0] bitcnt, xlen;
  logic [OW-1:0] ones;
  logic [REG_W-1:0] rx_sr;
  logic [TXW-1:0]   tx_sr, src;
  logic [7:0]   cmd_w, status;
  logic         cs_fall, cap, lau, tx_on;

  assign cs_fall = cs_p & ~cs_s;
  assign cap     = ~cs_s & (cpol ? (sk_s & ~sk_p) : (~sk_s & sk_p));
  assign lau     = ~cs_s & (cpol ? (~sk_s & sk_p) : (sk_s & ~sk_p));
  assign cmd_w   = {cmd_sr, di_s};
  assign status  = {rdy, 3'b000, 1'b1, 1'b0, standby, fsync};
  assign tx_on   = (st == ST_XFER && rw_q) || st == ST_CONT;
  assign dout_en = ~cs_s & tx_on;
  assign dout    = dout_en & dout_q;
  assign rdy_n   = ~rdy;

  always_comb begin
    if (reg_sel == 3'd0)          src = TXW'(status) << (TXW - 8);
    else if (reg_sel == DATA_SEL) src = TXW'(data_word) << (TXW - DATA_W);
    else                          src = TXW'(reg_rdata) << (TXW - REG_W);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {cs_m, cs_s, cs_p} <= 3'b111;
      {sk_m, sk_s, sk_p} <= 3'b111;
      {di_m, di_s}       <= 2'b00;
    end else begin
      cs_m <= cs_n; cs_s <= cs_m; cs_p <= cs_s;
      sk_m <= sclk; sk_s <= sk_m; sk_p <= sk_s;
      di_m <= din;  di_s <= di_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cpol <= 1'b1; rdy <= 1'b0; rw_q <= 1'b0;
      cont_arm <= 1'b0; dout_q <= 1'b0; cmd_sr <= '0; bitcnt <= '0;
      xlen <= '0; ones <= '0; rx_sr <= '0; tx_sr <= '0;
      reg_sel <= '0; reg_wdata <= '0; reg_wr <= 1'b0;
      standby <= 1'b0; fsync <= 1'b0; soft_rst <= 1'b0;
    end else begin
      reg_wr   <= 1'b0;
      soft_rst <= 1'b0;
      if (cs_fall) cpol <= sk_s;

      if (cs_s) begin
        st <= ST_IDLE; bitcnt <= '0; ones <= '0; cont_arm <= 1'b0;
      end else begin
        if (lau && tx_on) begin
          if (bitcnt == '0) begin
            dout_q <= src[TXW-1];
            tx_sr  <= src << 1;
          end else begin
            dout_q <= tx_sr[TXW-1];
            tx_sr  <= tx_sr << 1;
          end
        end

        if (cap) begin
          case (st)
            ST_IDLE: if (!di_s) begin
              st <= ST_CMD; bitcnt <= CW'(1); cmd_sr <= '0;
            end
            ST_CMD: begin
              cmd_sr <= {cmd_sr[5:0], di_s};
              bitcnt <= bitcnt + 1'b1;
              if (bitcnt == CW'(7)) begin
                bitcnt <= '0;
                if (cmd_w[2]) begin
                  reg_sel <= '0; standby <= 1'b0; fsync <= 1'b0;
                  rw_q <= 1'b0; rdy <= 1'b0; cont_arm <= 1'b0;
                  soft_rst <= 1'b1; st <= ST_IDLE;
                end else begin
                  reg_sel <= cmd_w[6:4]; rw_q <= cmd_w[3];
                  standby <= cmd_w[1];   fsync <= cmd_w[0];
                  cont_arm <= (cmd_w == {1'b0, 3'(DATA_SEL), 4'b1000}) && scan_en;
                  if (cmd_w[6:4] == 3'd0)            xlen <= CW'(8);
                  else if (cmd_w[6:4] == DATA_SEL)   xlen <= CW'(DATA_W);
                  else                               xlen <= CW'(REG_W);
                  st <= (cmd_w[6:4] == 3'd0 && !cmd_w[3]) ? ST_IDLE : ST_XFER;
                end
              end
            end
            ST_XFER: begin
              rx_sr  <= {rx_sr[REG_W-2:0], di_s};
              bitcnt <= bitcnt + 1'b1;
              if (bitcnt == xlen - 1'b1) begin
                bitcnt <= '0;
                if (!rw_q && reg_sel != 3'd0 && reg_sel != DATA_SEL) begin
                  reg_wr    <= 1'b1;
                  reg_wdata <= {rx_sr[REG_W-2:0], di_s};
                end
                if (rw_q && reg_sel == DATA_SEL) rdy <= 1'b0;
                st <= cont_arm ? ST_CONT : ST_IDLE;
              end
            end
            ST_CONT: begin
              if (bitcnt == '0 && !di_s) begin
                st <= ST_CMD; bitcnt <= CW'(1); cmd_sr <= '0; cont_arm <= 1'b0;
              end else if (bitcnt == CW'(DATA_W - 1)) begin
                bitcnt <= '0; rdy <= 1'b0;
              end else begin
                bitcnt <= bitcnt + 1'b1;
              end
            end
            default: st <= ST_IDLE;
          endcase

          if (st != ST_CONT) begin
            ones <= di_s ? ones + 1'b1 : '0;
            if (di_s && ones == OW'(RESYNC_ONES - 1)) begin
              ones <= '0; st <= ST_IDLE; bitcnt <= '0;
              cont_arm <= 1'b0; reg_wr <= 1'b0;
            end
          end
        end
      end

      if (data_valid) rdy <= 1'b1;
    end
  end
endmodule

module adc_cmd_port_chk #(
  parameter int DATA_SEL = 7
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       dout,
  input logic       dout_en,
  input logic       reg_wr,
  input logic [2:0] reg_sel,
  input logic       data_valid,
  input logic       rdy_n,
  input logic       soft_rst,
  input logic       standby,
  input logic       fsync,
  input logic       cs_fall,
  input logic       cpol
);
  assert_quiet_deselected_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2)) |-> (!dout_en && !dout));

  assert_wr_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  assert_wr_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> (reg_sel != 3'd0 && reg_sel != 3'(DATA_SEL)));

  assert_valid_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |=> !rdy_n);

  assert_soft_defaults_R10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> (!standby && !fsync && reg_sel == 3'd0));

  assert_polarity_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_fall |=> $stable(cpol));
endmodule

bind adc_cmd_port adc_cmd_port_chk #(.DATA_SEL(DATA_SEL)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .dout(dout), .dout_en(dout_en),
  .reg_wr(reg_wr), .reg_sel(reg_sel), .data_valid(data_valid), .rdy_n(rdy_n),
  .soft_rst(soft_rst), .standby(standby), .fsync(fsync),
  .cs_fall(cs_fall), .cpol(cpol)
);

// File: tb/adc_cmd_port_bench.sv
module adc_cmd_port_bench;
  localparam int CLK_P = 10;
  localparam int H     = 6;
  localparam int RW    = 40;

  logic clk = 0, rst_n = 0, cs_n = 0, sclk = 1, din = 0;
  logic dout, dout_en, data_valid = 0, scan_en = 0;
  logic [23:0] data_word = '0;
  logic [RW-1:0] reg_rdata = '0, reg_wdata;
  logic [2:0] reg_sel;
  logic reg_wr, standby, fsync, soft_rst, rdy_n;
  logic pol = 1;
  int checks = 0, errors = 0, wr_cnt = 0, srst_cnt = 0;
  logic [RW-1:0] wr_last = '0;

  adc_cmd_port #(.REG_W(RW)) u_adc_cmd_port (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .dout(dout), .dout_en(dout_en), .data_word(data_word),
    .data_valid(data_valid), .scan_en(scan_en), .reg_rdata(reg_rdata),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_wr(reg_wr),
    .standby(standby), .fsync(fsync), .soft_rst(soft_rst), .rdy_n(rdy_n)
  );

  always #(CLK_P/2) clk = ~clk;

  always @(negedge clk) begin
    if (reg_wr) begin wr_cnt++; wr_last = reg_wdata; end
    if (soft_rst) srst_cnt++;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic shift(input int n, input logic [63:0] bits,
                       output logic [63:0] got, output logic saw_en);
    got = '0; saw_en = 0;
    for (int i = n - 1; i >= 0; i--) begin
      sclk = ~pol; din = bits[i];
      tick(H);
      got[i] = dout; saw_en |= dout_en;
      sclk = pol;
      tick(H);
    end
  endtask

  task automatic select(input logic p);
    cs_n = 1; tick(H);
    sclk = p; pol = p; tick(H);
    cs_n = 0; tick(H);
  endtask

  task automatic pulse_valid(input logic [23:0] v);
    data_word = v; data_valid = 1; tick(1);
    data_valid = 0; tick(2);
  endtask

  logic [63:0] g;
  logic e;

  task automatic t_tied_low;
    chk("R2 rdy_n reset", rdy_n, 1);
    chk("R2 standby reset", standby, 0);
    chk("R2 reg_sel reset", reg_sel, 0);
    chk("R2 dout reset", dout, 0);
    shift(8, 8'h02, g, e);
    chk("R1 high idle without cs fall", standby, 1);
  endtask

  task automatic t_deselected;
    cs_n = 1; tick(H);
    chk("R2 dout_en deselected", dout_en, 0);
    chk("R2 dout deselected", dout, 0);
  endtask

  task automatic t_write;
    int w0 = wr_cnt;
    select(0);
    shift(8, 8'h22, g, e);
    shift(RW, 64'h12_3456_789A, g, e);
    chk("R3 reg_wr count", wr_cnt, w0 + 1);
    chk("R3 reg_wdata", wr_last, 64'h12_3456_789A);
    chk("R3 reg_sel", reg_sel, 2);
    chk("R1 R3 low idle standby", standby, 1);
  endtask

  task automatic t_read;
    reg_rdata = 40'hA5_5AC3_3C99;
    select(1);
    shift(8, 8'h38, g, e);
    shift(RW, 0, g, e);
    chk("R4 R1 register read", g, 64'hA5_5AC3_3C99);
    chk("R4 dout_en during read", e, 1);
    shift(8, 8'h0A, g, e);
    shift(8, 0, g, e);
    chk("R4 status byte", g, 8'h0A);
  endtask

  task automatic t_data;
    scan_en = 0;
    pulse_valid(24'hC35A96);
    chk("R5 ready set", rdy_n, 0);
    shift(8, 8'h78, g, e);
    shift(24, 24'hFFFFFF, g, e);
    chk("R5 data read", g, 24'hC35A96);
    chk("R5 ready cleared", rdy_n, 1);
    shift(24, 24'hFFFFFF, g, e);
    chk("R8 R6 no burst without scan", e, 0);
  endtask

  task automatic t_cont;
    scan_en = 1;
    pulse_valid(24'h123456);
    shift(8, 8'h78, g, e);
    shift(24, 24'hFFFFFF, g, e);
    chk("R8 first read", g, 24'h123456);
    pulse_valid(24'hABCDEF);
    shift(24, 24'hFFFFFF, g, e);
    chk("R8 burst read", g, 24'hABCDEF);
    chk("R8 burst clears ready", rdy_n, 1);
    shift(24, 24'hFFFFFF, g, e);
    chk("R8 repeat burst", g, 24'hABCDEF);
    shift(8, 8'h01, g, e);
    chk("R9 exit command fsync", fsync, 1);
    chk("R9 exit command standby", standby, 0);
    shift(24, 24'hFFFFFF, g, e);
    chk("R9 mode ended", e, 0);
    scan_en = 0;
  endtask

  task automatic t_resync;
    int w0;
    shift(8, 8'h22, g, e);
    w0 = wr_cnt;
    shift(4, 0, g, e);
    shift(32, 32'hFFFF_FFFF, g, e);
    chk("R7 no write after resync", wr_cnt, w0);
    chk("R7 standby kept", standby, 1);
    chk("R7 reg_sel kept", reg_sel, 2);
    shift(8, 8'h01, g, e);
    chk("R7 aligned after resync", {standby, fsync}, 2'b01);
  endtask

  task automatic t_abort;
    int w0 = wr_cnt;
    select(0);
    shift(8, 8'h22, g, e);
    shift(8, 8'hFF, g, e);
    select(0);
    shift(8, 8'h20, g, e);
    shift(RW, 1, g, e);
    chk("R11 one write only", wr_cnt, w0 + 1);
    chk("R11 clean data", wr_last, 1);
    shift(3, 3'b011, g, e);
    select(1);
    shift(8, 8'h02, g, e);
    chk("R11 partial command discarded", standby, 1);
  endtask

  task automatic t_soft;
    int s0 = srst_cnt;
    pulse_valid(24'h000001);
    chk("R10 ready before", rdy_n, 0);
    shift(8, 8'h04, g, e);
    chk("R10 soft_rst pulse", srst_cnt, s0 + 1);
    chk("R10 standby default", standby, 0);
    chk("R10 fsync default", fsync, 0);
    chk("R10 reg_sel default", reg_sel, 0);
    chk("R10 ready default", rdy_n, 1);
    shift(8, 8'h02, g, e);
    chk("R10 command wait after reset", standby, 1);
  endtask

  initial begin
    tick(5);
    rst_n = 1;
    tick(H);
    t_tied_low();
    t_deselected();
    t_write();
    t_read();
    t_data();
    t_cont();
    t_resync();
    t_abort();
    t_soft();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule